// File: doc/BRIEF.md
# Dual-Mailbox Byte Bridge

This block passes single bytes in both directions between an ISA-style host I/O bus and a slow 8-bit microcontroller bus. Each direction has its own one-byte holding register and a full flag. The host learns the state of both registers by polling a status port. The microcontroller is told of a new inbound byte by an active-low interrupt, and it polls a busy output to know when the host has collected its outbound byte.

Both buses are treated as active-low strobes that are sampled on one clock. An access is acted on once, in the cycle its decoded strobe first becomes active. Holding a strobe low for longer does not repeat the update. Read data is driven whenever a read is decoded, and a drive-enable output tells the pad logic when to turn the bus around.

Top module: `mbox_bridge`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mcu_irq_n` is 1 and `mcu_tx_busy` is 0. A status read then returns 0x02.
- R2: Host accesses are decoded only when `host_aen` is 0 and `host_addr` equals 0x220 (data) or 0x221 (status). Any other address, or `host_aen` at 1, changes nothing. In that case `host_rd_oe` is 0 and `host_rdata` is 0.
- R3: On the first cycle of a host write to 0x220 (`host_iow_n` low), `host_wdata` is stored in the inbound register. From the next cycle `mcu_irq_n` is 0.
- R4: While `mcu_sel` is 2'b01 and `mcu_rd_n` is 0, `mcu_rdata` shows the inbound register and `mcu_rd_oe` is 1. Otherwise both are 0. On the first cycle of such a read, `mcu_irq_n` returns to 1 in the next cycle.
- R5: On the first cycle of a microcontroller write (`mcu_sel` 2'b10, `mcu_wr_n` low), `mcu_wdata` is stored in the outbound register. From the next cycle `mcu_tx_busy` is 1.
- R6: While a host read of 0x220 is decoded, `host_rdata` shows the outbound register and `host_rd_oe` is 1. On its first cycle, `mcu_tx_busy` clears in the next cycle.
- R7: A host read of 0x221 returns the following: bit 0 equals `mcu_tx_busy` (outbound byte waiting), bit 1 equals `mcu_irq_n` (last inbound byte taken), and bits 7..2 are 0.
- R8: A strobe held active for many cycles causes only one update. A byte written into the outbound register during a long host read of 0x220 therefore leaves `mcu_tx_busy` set.
- R9: Writing a register again while it is still full replaces the byte, and its flag stays set.
- R10: If a fill and an empty of the same register start in the same cycle, the fill wins: the flag ends set and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both bus samplers |
| rst | input | 1 | Synchronous system reset, active high |
| host_addr | input | 10 | Host I/O address |
| host_aen | input | 1 | High during DMA cycles; blocks host decode |
| host_ior_n | input | 1 | Host I/O read strobe, active low |
| host_iow_n | input | 1 | Host I/O write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (0 when no read is decoded) |
| host_rd_oe | output | 1 | Host read data drive enable |
| mcu_sel | input | 2 | Top two microcontroller address bits |
| mcu_rd_n | input | 1 | Microcontroller read strobe, active low |
| mcu_wr_n | input | 1 | Microcontroller write strobe, active low |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_rdata | output | 8 | Microcontroller read data (0 when no read is decoded) |
| mcu_rd_oe | output | 1 | Microcontroller read data drive enable |
| mcu_irq_n | output | 1 | Inbound byte waiting, active low |
| mcu_tx_busy | output | 1 | Outbound byte not yet collected by host |

## Verification
The hardest situations to reach are two strobes starting in the same cycle on one register, and a second strobe starting while another is held. Ordinary request/response traffic never lines these up. The stimulus builds both cases by hand: it asserts a host read and a microcontroller write together, and it opens a long host read into which a microcontroller write is slid. A stretch of random strobes and addresses, compared cycle by cycle against a behavioural model, then covers collisions that were not planned.

// File: rtl/mbox_bridge.sv
module mbox_bridge #(
  parameter int DW = 8,
  parameter int AW = 10,
  parameter int SW = 2,
  parameter logic [AW-1:0] DATA_PORT = 10'h220,
  parameter logic [AW-1:0] STAT_PORT = 10'h221,
  parameter logic [SW-1:0] MCU_RD_SEL = 2'b01,
  parameter logic [SW-1:0] MCU_WR_SEL = 2'b10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_addr,
  input  logic          host_aen,
  input  logic          host_ior_n,
  input  logic          host_iow_n,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rd_oe,
  input  logic [SW-1:0] mcu_sel,
  input  logic          mcu_rd_n,
  input  logic          mcu_wr_n,
  input  logic [DW-1:0] mcu_wdata,
  output logic [DW-1:0] mcu_rdata,
  output logic          mcu_rd_oe,
  output logic          mcu_irq_n,
  output logic          mcu_tx_busy
);
  localparam int PADW = DW - 2;

  logic          h_data, h_stat;
  logic          h_rd_data, h_rd_stat, h_wr_data;
  logic          m_rd, m_wr;
  logic          h_rd_q, h_wr_q, m_rd_q, m_wr_q;
  logic          h_rd_go, h_wr_go, m_rd_go, m_wr_go;
  logic          in_full, out_full;
  logic [DW-1:0] in_buf, out_buf;
  logic [DW-1:0] status;

  assign h_data    = !host_aen && (host_addr == DATA_PORT);
  assign h_stat    = !host_aen && (host_addr == STAT_PORT);
  assign h_rd_data = h_data && !host_ior_n;
  assign h_rd_stat = h_stat && !host_ior_n;
  assign h_wr_data = h_data && !host_iow_n;
  assign m_rd      = (mcu_sel == MCU_RD_SEL) && !mcu_rd_n;
  assign m_wr      = (mcu_sel == MCU_WR_SEL) && !mcu_wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rd_q <= 1'b0;
      h_wr_q <= 1'b0;
      m_rd_q <= 1'b0;
      m_wr_q <= 1'b0;
    end else begin
      h_rd_q <= h_rd_data;
      h_wr_q <= h_wr_data;
      m_rd_q <= m_rd;
      m_wr_q <= m_wr;
    end
  end

  assign h_rd_go = h_rd_data && !h_rd_q;
  assign h_wr_go = h_wr_data && !h_wr_q;
  assign m_rd_go = m_rd && !m_rd_q;
  assign m_wr_go = m_wr && !m_wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_full <= 1'b0;
      in_buf  <= '0;
    end else if (h_wr_go) begin
      in_full <= 1'b1;
      in_buf  <= host_wdata;
    end else if (m_rd_go) begin
      in_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_full <= 1'b0;
      out_buf  <= '0;
    end else if (m_wr_go) begin
      out_full <= 1'b1;
      out_buf  <= mcu_wdata;
    end else if (h_rd_go) begin
      out_full <= 1'b0;
    end
  end

  assign status      = {{PADW{1'b0}}, !in_full, out_full};
  assign host_rd_oe  = h_rd_data || h_rd_stat;
  assign host_rdata  = h_rd_data ? out_buf : (h_rd_stat ? status : '0);
  assign mcu_rd_oe   = m_rd;
  assign mcu_rdata   = m_rd ? in_buf : '0;
  assign mcu_irq_n   = !in_full;
  assign mcu_tx_busy = out_full;
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk #(
  parameter int DW = 8,
  parameter int AW = 10,
  parameter int SW = 2,
  parameter logic [AW-1:0] DATA_PORT = 10'h220,
  parameter logic [AW-1:0] STAT_PORT = 10'h221,
  parameter logic [SW-1:0] MCU_RD_SEL = 2'b01,
  parameter logic [SW-1:0] MCU_WR_SEL = 2'b10
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] host_addr,
  input logic          host_aen,
  input logic          host_ior_n,
  input logic          host_iow_n,
  input logic [DW-1:0] host_rdata,
  input logic          host_rd_oe,
  input logic [SW-1:0] mcu_sel,
  input logic          mcu_rd_n,
  input logic          mcu_wr_n,
  input logic          mcu_rd_oe,
  input logic          mcu_irq_n,
  input logic          mcu_tx_busy
);
  logic hw, hr, hs, mr, mw;
  assign hw = !host_aen && host_addr == DATA_PORT && !host_iow_n;
  assign hr = !host_aen && host_addr == DATA_PORT && !host_ior_n;
  assign hs = !host_aen && host_addr == STAT_PORT && !host_ior_n;
  assign mr = mcu_sel == MCU_RD_SEL && !mcu_rd_n;
  assign mw = mcu_sel == MCU_WR_SEL && !mcu_wr_n;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (mcu_irq_n && !mcu_tx_busy));
  // R2
  oe_decode_chk: assert property (@(posedge clk) disable iff (rst) !(hr || hs) |-> (!host_rd_oe && host_rdata == '0));
  // R3
  in_fill_chk: assert property (@(posedge clk) disable iff (rst) (hw && !$past(hw)) |=> !mcu_irq_n);
  // R4
  in_take_chk: assert property (@(posedge clk) disable iff (rst) (mr && !$past(mr) && !(hw && !$past(hw))) |=> mcu_irq_n);
  // R4
  mcu_oe_chk: assert property (@(posedge clk) disable iff (rst) mcu_rd_oe == mr);
  // R5
  out_fill_chk: assert property (@(posedge clk) disable iff (rst) (mw && !$past(mw)) |=> mcu_tx_busy);
  // R6
  out_take_chk: assert property (@(posedge clk) disable iff (rst) (hr && !$past(hr) && !(mw && !$past(mw))) |=> !mcu_tx_busy);
  // R7
  status_chk: assert property (@(posedge clk) disable iff (rst) (hs && !hr) |-> (host_rd_oe && host_rdata[DW-1:2] == '0 && host_rdata[0] == mcu_tx_busy && host_rdata[1] == mcu_irq_n));
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst) (!(hw && !$past(hw)) && !(mr && !$past(mr))) |=> $stable(mcu_irq_n));
endmodule

bind mbox_bridge mbox_bridge_chk #(
  .DW(DW), .AW(AW), .SW(SW), .DATA_PORT(DATA_PORT), .STAT_PORT(STAT_PORT),
  .MCU_RD_SEL(MCU_RD_SEL), .MCU_WR_SEL(MCU_WR_SEL)
) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_aen(host_aen),
  .host_ior_n(host_ior_n), .host_iow_n(host_iow_n), .host_rdata(host_rdata),
  .host_rd_oe(host_rd_oe), .mcu_sel(mcu_sel), .mcu_rd_n(mcu_rd_n),
  .mcu_wr_n(mcu_wr_n), .mcu_rd_oe(mcu_rd_oe), .mcu_irq_n(mcu_irq_n),
  .mcu_tx_busy(mcu_tx_busy)
);

// File: tb/mbox_bridge_tb.sv
module mbox_bridge_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] host_addr = '0;
  logic       host_aen = 1'b0, host_ior_n = 1'b1, host_iow_n = 1'b1;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       host_rd_oe;
  logic [1:0] mcu_sel = '0;
  logic       mcu_rd_n = 1'b1, mcu_wr_n = 1'b1;
  logic [7:0] mcu_wdata = '0, mcu_rdata;
  logic       mcu_rd_oe, mcu_irq_n, mcu_tx_busy;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] got;

  // behavioural reference
  logic [7:0] r_in = 0, r_out = 0;
  bit r_in_full = 0, r_out_full = 0;
  bit p_hw = 0, p_hr = 0, p_mr = 0, p_mw = 0;

  mbox_bridge u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_aen(host_aen),
    .host_ior_n(host_ior_n), .host_iow_n(host_iow_n), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rd_oe(host_rd_oe), .mcu_sel(mcu_sel),
    .mcu_rd_n(mcu_rd_n), .mcu_wr_n(mcu_wr_n), .mcu_wdata(mcu_wdata),
    .mcu_rdata(mcu_rdata), .mcu_rd_oe(mcu_rd_oe), .mcu_irq_n(mcu_irq_n),
    .mcu_tx_busy(mcu_tx_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit e_hw(); return !host_aen && host_addr == 10'h220 && !host_iow_n; endfunction
  function automatic bit e_hr(); return !host_aen && host_addr == 10'h220 && !host_ior_n; endfunction
  function automatic bit e_hs(); return !host_aen && host_addr == 10'h221 && !host_ior_n; endfunction
  function automatic bit e_mr(); return mcu_sel == 2'b01 && !mcu_rd_n; endfunction
  function automatic bit e_mw(); return mcu_sel == 2'b10 && !mcu_wr_n; endfunction

  always @(posedge clk) begin
    if (rst) begin
      r_in_full = 0; r_out_full = 0; r_in = 0; r_out = 0;
      p_hw = 0; p_hr = 0; p_mr = 0; p_mw = 0;
    end else begin
      if (e_hw() && !p_hw) begin r_in_full = 1; r_in = host_wdata; end
      else if (e_mr() && !p_mr) r_in_full = 0;
      if (e_mw() && !p_mw) begin r_out_full = 1; r_out = mcu_wdata; end
      else if (e_hr() && !p_hr) r_out_full = 0;
      p_hw = e_hw(); p_hr = e_hr(); p_mr = e_mr(); p_mw = e_mw();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] exp_h;
    exp_h = e_hr() ? r_out : (e_hs() ? {6'b0, !r_in_full, r_out_full} : 8'h00);
    check(mcu_irq_n == !r_in_full, "R3 irq", mcu_irq_n, !r_in_full);
    check(mcu_tx_busy == r_out_full, "R5 busy", mcu_tx_busy, r_out_full);
    check(host_rdata == exp_h, "R6 host_rdata", host_rdata, exp_h);
    check(host_rd_oe == (e_hr() || e_hs()), "R2 host_rd_oe", host_rd_oe, e_hr() || e_hs());
    check(mcu_rd_oe == e_mr(), "R4 mcu_rd_oe", mcu_rd_oe, e_mr());
    check(mcu_rdata == (e_mr() ? r_in : 8'h00), "R4 mcu_rdata", mcu_rdata, e_mr() ? r_in : 8'h00);
  end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic idle();
    host_ior_n = 1; host_iow_n = 1; mcu_rd_n = 1; mcu_wr_n = 1; host_aen = 0;
  endtask

  task automatic h_wr(input logic [9:0] a, input logic [7:0] d, input bit aen);
    host_addr = a; host_wdata = d; host_aen = aen; host_iow_n = 0;
    tick(); tick(); idle(); tick();
  endtask

  task automatic h_rd(input logic [9:0] a, output logic [7:0] d);
    host_addr = a; host_ior_n = 0; #1 d = host_rdata;
    tick(); tick(); idle(); tick();
  endtask

  task automatic m_wr(input logic [7:0] d);
    mcu_sel = 2'b10; mcu_wdata = d; mcu_wr_n = 0;
    tick(); tick(); idle(); tick();
  endtask

  task automatic m_rd(output logic [7:0] d);
    mcu_sel = 2'b01; mcu_rd_n = 0; #1 d = mcu_rdata;
    tick(); tick(); idle(); tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rst = 0; #1;
    // R1
    check(mcu_irq_n == 1 && mcu_tx_busy == 0, "R1 reset flags", {mcu_irq_n, mcu_tx_busy}, 2'b10);
    tick();
    h_rd(10'h221, got);
    check(got == 8'h02, "R1 reset status", got, 8'h02);
    // R2
    h_wr(10'h222, 8'h99, 0);
    h_wr(10'h220, 8'h98, 1);
    check(mcu_irq_n == 1, "R2 stray write ignored", mcu_irq_n, 1);
    h_rd(10'h223, got);
    check(got == 8'h00, "R2 stray read", got, 0);
    // R3 R4
    h_wr(10'h220, 8'hA5, 0);
    check(mcu_irq_n == 0, "R3 irq asserted", mcu_irq_n, 0);
    m_rd(got);
    check(got == 8'hA5, "R4 inbound byte", got, 8'hA5);
    check(mcu_irq_n == 1, "R4 irq released", mcu_irq_n, 1);
    // R5 R7 R6
    m_wr(8'h3C);
    check(mcu_tx_busy == 1, "R5 busy set", mcu_tx_busy, 1);
    h_rd(10'h221, got);
    check(got == 8'h03, "R7 status", got, 8'h03);
    h_rd(10'h220, got);
    check(got == 8'h3C, "R6 outbound byte", got, 8'h3C);
    check(mcu_tx_busy == 0, "R6 busy cleared", mcu_tx_busy, 0);
    // R9
    m_wr(8'h11); m_wr(8'h22);
    check(mcu_tx_busy == 1, "R9 busy kept", mcu_tx_busy, 1);
    h_rd(10'h220, got);
    check(got == 8'h22, "R9 out overwrite", got, 8'h22);
    h_wr(10'h220, 8'h55, 0); h_wr(10'h220, 8'h66, 0);
    m_rd(got);
    check(got == 8'h66, "R9 in overwrite", got, 8'h66);
    // R8: long host read, MCU write slid in
    host_addr = 10'h220; host_ior_n = 0;
    tick(); tick(); tick();
    mcu_sel = 2'b10; mcu_wdata = 8'h5A; mcu_wr_n = 0;
    tick(); mcu_wr_n = 1; tick(); tick();
    idle(); tick();
    check(mcu_tx_busy == 1, "R8 held strobe no repeat", mcu_tx_busy, 1);
    h_rd(10'h220, got);
    check(got == 8'h5A, "R8 byte", got, 8'h5A);
    // R10 outbound collision
    m_wr(8'h77);
    host_addr = 10'h220; host_ior_n = 0; mcu_sel = 2'b10; mcu_wdata = 8'h88; mcu_wr_n = 0;
    #1 check(host_rdata == 8'h77, "R10 old byte seen", host_rdata, 8'h77);
    tick(); idle(); tick();
    check(mcu_tx_busy == 1, "R10 fill wins out", mcu_tx_busy, 1);
    h_rd(10'h220, got);
    check(got == 8'h88, "R10 new out byte", got, 8'h88);
    // R10 inbound collision
    h_wr(10'h220, 8'h12, 0);
    host_addr = 10'h220; host_wdata = 8'h34; host_iow_n = 0; mcu_sel = 2'b01; mcu_rd_n = 0;
    tick(); idle(); tick();
    check(mcu_irq_n == 0, "R10 fill wins in", mcu_irq_n, 0);
    m_rd(got);
    check(got == 8'h34, "R10 new in byte", got, 8'h34);
    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      host_addr  = ($urandom % 4 == 0) ? 10'($urandom) : 10'h220 + 10'($urandom % 2);
      host_aen   = ($urandom % 8 == 0);
      host_ior_n = ($urandom % 3 != 0);
      host_iow_n = ($urandom % 3 != 0);
      host_wdata = 8'($urandom);
      mcu_sel    = 2'($urandom);
      mcu_rd_n   = ($urandom % 3 != 0);
      mcu_wr_n   = ($urandom % 3 != 0);
      mcu_wdata  = 8'($urandom);
      if (i == 1000) rst = 1;
      if (i == 1002) rst = 0;
      tick();
    end
    idle(); tick(); tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule